// File: doc/BRIEF.md
# Vectored 64-Source Interrupt Controller

This block gathers up to 64 interrupt request lines and forwards them to a smaller set of parent interrupt outputs. Each source can trigger on a rising edge or on a level, can be masked, and carries a request bit and an in-service bit. A per-source vector byte picks the parent output that the source drives. When several sources share one output, that output is the OR of all of them.

Software reaches the block through a simple strobe-based register port. Registers that span all 64 sources are split into 32-bit low and high words. The vector and route tables are reached one byte at a time. The route table, the polarity word and the message-enable word are plain storage with no effect on delivery. The two automatic-control words always read as zero.

Source inputs are synchronous to the block clock. The reset input is asynchronous and active low, and the block releases it internally on a clock edge.

Top module: `vec_irq_ctrl`

## Requirements
- R1: With its edge-select bit set to 1, a source latches a request only on a low-to-high change of its input compared with the previous cycle. An input held high latches nothing more after the request is cleared.
- R2: With its edge-select bit at 0, a source's request follows its input. Whenever an input falls, in either mode, the source's in-service bit clears and it stops driving its output after one clock edge.
- R3: An unmasked in-service source drives parent output number equal to its vector byte. A vector value of NOUT or more drives no output. An output shared by several sources stays high while any of them is in service.
- R4: A mask bit of 1 blocks its source. Changing a mask bit from 1 to 0 while a request is pending sets in-service and drives the output at once. Changing it from 0 to 1 clears in-service.
- R5: Writing the clear word acts only on sources whose edge-select bit is 1: their request and in-service bits are cleared. Level-mode sources are unaffected.
- R6: A status read returns the in-service bits ANDed with the inverted mask. A status write replaces that half of the in-service bits, which then drive outputs like any other in-service bits.
- R7: The ID high word reads {NSRC-1 in bits 31:16, VERSION in bits 15:0}. The ID low word reads the ID_WORD parameter.
- R8: After reset: mask all ones, edge-select 0, polarity 0, in-service 0, every route byte 1, every vector byte 0, all outputs low.
- R9: A word write replaces only the addressed 32-bit half of a 64-bit register. The high half covers sources 32 to 63, with bit n of that word belonging to source 32+n.
- R10: The message-enable word, the polarity word and the route bytes read back what was written and affect nothing else. The automatic-control words at 0x028 to 0x034 read zero and ignore writes.
- R11: Read data appears on reg_rdata one cycle after a read strobe, and it is zero in any cycle that follows a cycle without a read strobe. A write takes effect on the next clock edge.
- R12: Word offsets (reg_byte=0): ID 0x000/0x004, mask 0x008/0x00C, edge-select 0x010/0x014, clear 0x018/0x01C, message-enable 0x020/0x024, status 0x040/0x044, polarity 0x048/0x04C (low/high). Byte offsets (reg_byte=1): route entry i at 0x100+i, vector entry i at 0x200+i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Interrupt source levels, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_byte | input | 1 | 1 selects byte tables, 0 selects 32-bit words |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data (bits 7:0 for byte writes) |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| irq_out | output | NOUT | Parent interrupt outputs |

## Verification
The bench steers an edge source and a level source onto the same output and drops one of them while the other stays high. A design that drives the output from the last event would drop the output there. It toggles the mask on an edge source whose input already fell, so a design that ignores the pending request on unmask would leave the output low. It issues clear writes that cover a level source, which a design not gated by edge-select would wrongly clear. It also holds an edge input high after a clear, which a level-sensitive latch would retrigger, and sets a vector byte past the output count, which a design that truncates the index would alias onto a real output.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int REG_W  = 64;
  localparam int HALF_W = 32;
  localparam int IDX_W  = $clog2(REG_W);

  localparam logic [11:0] A_ID_LO   = 12'h000;
  localparam logic [11:0] A_ID_HI   = 12'h004;
  localparam logic [11:0] A_MASK_LO = 12'h008;
  localparam logic [11:0] A_MASK_HI = 12'h00C;
  localparam logic [11:0] A_EDGE_LO = 12'h010;
  localparam logic [11:0] A_EDGE_HI = 12'h014;
  localparam logic [11:0] A_CLR_LO  = 12'h018;
  localparam logic [11:0] A_CLR_HI  = 12'h01C;
  localparam logic [11:0] A_MSG_LO  = 12'h020;
  localparam logic [11:0] A_MSG_HI  = 12'h024;
  localparam logic [11:0] A_STAT_LO = 12'h040;
  localparam logic [11:0] A_STAT_HI = 12'h044;
  localparam logic [11:0] A_POL_LO  = 12'h048;
  localparam logic [11:0] A_POL_HI  = 12'h04C;

  localparam logic [3:0] PAGE_ROUTE = 4'h1;
  localparam logic [3:0] PAGE_VEC   = 4'h2;

  function automatic logic [REG_W-1:0] put_half(
    input logic [REG_W-1:0]  old_v,
    input logic [HALF_W-1:0] data,
    input logic              hi
  );
    put_half = hi ? {data, old_v[HALF_W-1:0]} : {old_v[REG_W-1:HALF_W], data};
  endfunction
endpackage

// File: rtl/pic_src_bank.sv
module pic_src_bank
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  src,
  input  logic [REG_W-1:0]  edge_sel,
  input  logic [REG_W-1:0]  mask_q,
  input  logic [REG_W-1:0]  mask_d,
  input  logic              clr_en,
  input  logic [REG_W-1:0]  clr_bits,
  input  logic              isr_wr_en,
  input  logic              isr_wr_hi,
  input  logic [HALF_W-1:0] isr_wr_data,
  output logic [REG_W-1:0]  isr_q
);
  logic [REG_W-1:0] irr_q, irr_d, prev_q, isr_d;
  logic [REG_W-1:0] rise, fall, clr_eff, unmask, newmask, drop, arm, isr_calc;

  always_comb begin
    rise     = src & ~prev_q;
    fall     = ~src & prev_q;
    clr_eff  = clr_en ? (clr_bits & edge_sel) : '0;
    irr_d    = (edge_sel & (irr_q | rise) & ~clr_eff) | (~edge_sel & src);
    unmask   = mask_q & ~mask_d;
    newmask  = ~mask_q & mask_d;
    drop     = fall | newmask | clr_eff;
    arm      = rise | unmask;
    isr_calc = (isr_q & ~drop) | (arm & irr_d & ~mask_d);
    isr_d    = isr_wr_en ? put_half(isr_calc, isr_wr_data, isr_wr_hi) : isr_calc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      prev_q <= '0;
    end else begin
      irr_q  <= irr_d;
      isr_q  <= isr_d;
      prev_q <= src;
    end
  end

  // A falling input leaves no in-service bit behind
  assert_fall_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((fall != '0) && !isr_wr_en) |=> ((isr_q & $past(fall)) == '0));

  // In-service never becomes set on a masked source without a software write
  assert_masked_no_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !isr_wr_en |=> ((isr_q & ~$past(isr_q) & mask_q) == '0));

  // Clear removes edge requests
  assert_clear_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((irr_q & $past(clr_bits & edge_sel)) == '0));

  // Clear leaves level requests following their inputs
  assert_clear_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((irr_q & ~$past(edge_sel)) == ($past(src) & ~$past(edge_sel))));
endmodule

// File: rtl/pic_vec_table.sv
module pic_vec_table
  import pic_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  sel_vec,
  input  logic [IDX_W-1:0]      idx,
  input  logic [7:0]            wdata,
  output logic [REG_W-1:0][7:0] route_tab,
  output logic [REG_W-1:0][7:0] vec_tab
);
  logic [REG_W-1:0][7:0] route_d, vec_d;

  always_comb begin
    route_d = route_tab;
    vec_d   = vec_tab;
    if (wr_en) begin
      if (sel_vec) vec_d[idx]   = wdata;
      else         route_d[idx] = wdata;
    end
  end

  generate
    for (genvar i = 0; i < REG_W; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          route_tab[i] <= 8'h01;
          vec_tab[i]   <= 8'h00;
        end else if (wr_en && (idx == IDX_W'(i))) begin
          route_tab[i] <= route_d[i];
          vec_tab[i]   <= vec_d[i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pic_out_map.sv
module pic_out_map
  import pic_pkg::*;
#(
  parameter int NOUT = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_W-1:0]      active,
  input  logic [REG_W-1:0][7:0] vec_tab,
  output logic [NOUT-1:0]       irq_out
);
  generate
    for (genvar k = 0; k < NOUT; k++) begin : g_out
      logic hit;
      always_comb begin
        hit = 1'b0;
        for (int s = 0; s < REG_W; s++) begin
          if (active[s] && (vec_tab[s] == 8'(k))) hit = 1'b1;
        end
      end
      assign irq_out[k] = hit;
    end
  endgenerate

  // With nothing in service, every parent output is low
  assert_out_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |-> (irq_out == '0));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import pic_pkg::*;
#(
  parameter int          NSRC    = 64,
  parameter int          NOUT    = 32,
  parameter logic [15:0] VERSION = 16'h0001,
  parameter logic [31:0] ID_WORD = 32'h0000_0007
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_in,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic             reg_byte,
  input  logic [11:0]      reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic [NOUT-1:0]  irq_out
);
  localparam logic [31:0] ID_HI_VAL = {16'(NSRC - 1), VERSION};

  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  logic [11:0]      waddr;
  logic             word_wr, tbl_hit, tbl_wr;
  logic [REG_W-1:0] src_full, mask_q, mask_d, edge_q, edge_d;
  logic [REG_W-1:0] msg_q, msg_d, pol_q, pol_d, clr_bits, isr_q, active;
  logic             clr_en, isr_wr_en, isr_wr_hi;
  logic [31:0]      rdata_q, rdata_d;
  logic [REG_W-1:0][7:0] route_tab, vec_tab;

  assign src_full = REG_W'(src_in);
  assign waddr    = {reg_addr[11:2], 2'b00};
  assign word_wr  = reg_wr & ~reg_byte;
  assign tbl_hit  = reg_byte && (reg_addr[7:6] == 2'b00) &&
                    ((reg_addr[11:8] == PAGE_ROUTE) || (reg_addr[11:8] == PAGE_VEC));
  assign tbl_wr   = reg_wr & tbl_hit;

  always_comb begin
    mask_d    = mask_q;
    edge_d    = edge_q;
    msg_d     = msg_q;
    pol_d     = pol_q;
    clr_en    = 1'b0;
    clr_bits  = '0;
    isr_wr_en = 1'b0;
    isr_wr_hi = 1'b0;
    if (word_wr) begin
      case (waddr)
        A_MASK_LO: mask_d = put_half(mask_q, reg_wdata, 1'b0);
        A_MASK_HI: mask_d = put_half(mask_q, reg_wdata, 1'b1);
        A_EDGE_LO: edge_d = put_half(edge_q, reg_wdata, 1'b0);
        A_EDGE_HI: edge_d = put_half(edge_q, reg_wdata, 1'b1);
        A_MSG_LO:  msg_d  = put_half(msg_q, reg_wdata, 1'b0);
        A_MSG_HI:  msg_d  = put_half(msg_q, reg_wdata, 1'b1);
        A_POL_LO:  pol_d  = put_half(pol_q, reg_wdata, 1'b0);
        A_POL_HI:  pol_d  = put_half(pol_q, reg_wdata, 1'b1);
        A_CLR_LO: begin
          clr_en   = 1'b1;
          clr_bits = put_half('0, reg_wdata, 1'b0);
        end
        A_CLR_HI: begin
          clr_en   = 1'b1;
          clr_bits = put_half('0, reg_wdata, 1'b1);
        end
        A_STAT_LO: isr_wr_en = 1'b1;
        A_STAT_HI: begin
          isr_wr_en = 1'b1;
          isr_wr_hi = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign active = isr_q & ~mask_q;

  always_comb begin
    rdata_d = '0;
    if (reg_rd) begin
      if (reg_byte) begin
        if (tbl_hit) begin
          rdata_d[7:0] = (reg_addr[11:8] == PAGE_VEC) ? vec_tab[reg_addr[5:0]]
                                                      : route_tab[reg_addr[5:0]];
        end
      end else begin
        case (waddr)
          A_ID_LO:   rdata_d = ID_WORD;
          A_ID_HI:   rdata_d = ID_HI_VAL;
          A_MASK_LO: rdata_d = mask_q[HALF_W-1:0];
          A_MASK_HI: rdata_d = mask_q[REG_W-1:HALF_W];
          A_EDGE_LO: rdata_d = edge_q[HALF_W-1:0];
          A_EDGE_HI: rdata_d = edge_q[REG_W-1:HALF_W];
          A_MSG_LO:  rdata_d = msg_q[HALF_W-1:0];
          A_MSG_HI:  rdata_d = msg_q[REG_W-1:HALF_W];
          A_STAT_LO: rdata_d = active[HALF_W-1:0];
          A_STAT_HI: rdata_d = active[REG_W-1:HALF_W];
          A_POL_LO:  rdata_d = pol_q[HALF_W-1:0];
          A_POL_HI:  rdata_d = pol_q[REG_W-1:HALF_W];
          default:   rdata_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '1;
      edge_q  <= '0;
      msg_q   <= '0;
      pol_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (word_wr) begin
        mask_q <= mask_d;
        edge_q <= edge_d;
        msg_q  <= msg_d;
        pol_q  <= pol_d;
      end
      rdata_q <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;

  pic_src_bank u_src (
    .clk         (clk),
    .rst_n       (rst_ni),
    .src         (src_full),
    .edge_sel    (edge_q),
    .mask_q      (mask_q),
    .mask_d      (mask_d),
    .clr_en      (clr_en),
    .clr_bits    (clr_bits),
    .isr_wr_en   (isr_wr_en),
    .isr_wr_hi   (isr_wr_hi),
    .isr_wr_data (reg_wdata),
    .isr_q       (isr_q)
  );

  pic_vec_table u_tab (
    .clk       (clk),
    .rst_n     (rst_ni),
    .wr_en     (tbl_wr),
    .sel_vec   (reg_addr[9]),
    .idx       (reg_addr[5:0]),
    .wdata     (reg_wdata[7:0]),
    .route_tab (route_tab),
    .vec_tab   (vec_tab)
  );

  pic_out_map #(.NOUT(NOUT)) u_map (
    .clk     (clk),
    .rst_n   (rst_ni),
    .active  (active),
    .vec_tab (vec_tab),
    .irq_out (irq_out)
  );

  // Read data is zero after any cycle without a read strobe
  assert_rd_idle_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    !reg_rd |=> (reg_rdata == '0));
endmodule

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 64;
  localparam int NOUT = 32;

  localparam logic [2:0] OP_WW = 3'd0;
  localparam logic [2:0] OP_WB = 3'd1;
  localparam logic [2:0] OP_RW = 3'd2;
  localparam logic [2:0] OP_RB = 3'd3;
  localparam logic [2:0] OP_SR = 3'd4;
  localparam logic [2:0] OP_OT = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  req;
    logic [11:0] addr;
    logic [63:0] data;
    logic [31:0] exp;
  } step_t;

  localparam int NSTEP = 64;
  localparam step_t TBL [NSTEP] = '{
    '{OP_RW, 4'd7,  12'h004, 64'h0, 32'h003F_0001},            // R7
    '{OP_RW, 4'd7,  12'h000, 64'h0, 32'h0000_0007},            // R7
    '{OP_WB, 4'd3,  12'h202, 64'h5, 32'h0},
    '{OP_WW, 4'd4,  12'h008, 64'hFFFF_FFFB, 32'h0},
    '{OP_SR, 4'd2,  12'h000, 64'h4, 32'h0},
    '{OP_OT, 4'd2,  12'h000, 64'h0, 32'h0000_0020},            // R2 level up
    '{OP_SR, 4'd2,  12'h000, 64'h0, 32'h0},
    '{OP_OT, 4'd2,  12'h000, 64'h0, 32'h0},                    // R2 level down
    '{OP_WW, 4'd1,  12'h010, 64'h1, 32'h0},
    '{OP_WB, 4'd3,  12'h200, 64'h5, 32'h0},
    '{OP_WW, 4'd4,  12'h008, 64'hFFFF_FFFA, 32'h0},
    '{OP_SR, 4'd3,  12'h000, 64'h5, 32'h0},
    '{OP_OT, 4'd3,  12'h000, 64'h0, 32'h0000_0020},            // R3 shared
    '{OP_SR, 4'd3,  12'h000, 64'h4, 32'h0},
    '{OP_OT, 4'd3,  12'h000, 64'h0, 32'h0000_0020},            // R3 no cancel
    '{OP_SR, 4'd3,  12'h000, 64'h0, 32'h0},
    '{OP_WW, 4'd4,  12'h008, 64'hFFFF_FFFF, 32'h0},
    '{OP_WW, 4'd4,  12'h008, 64'hFFFF_FFFA, 32'h0},
    '{OP_OT, 4'd4,  12'h000, 64'h0, 32'h0000_0020},            // R4 unmask pending
    '{OP_RW, 4'd6,  12'h040, 64'h0, 32'h0000_0001},            // R6
    '{OP_WW, 4'd4,  12'h008, 64'hFFFF_FFFB, 32'h0},
    '{OP_OT, 4'd4,  12'h000, 64'h0, 32'h0},                    // R4 mask drops
    '{OP_WW, 4'd5,  12'h018, 64'h5, 32'h0},
    '{OP_WW, 4'd5,  12'h008, 64'hFFFF_FFFA, 32'h0},
    '{OP_OT, 4'd5,  12'h000, 64'h0, 32'h0},                    // R5 edge cleared
    '{OP_SR, 4'd5,  12'h000, 64'h4, 32'h0},
    '{OP_OT, 4'd5,  12'h000, 64'h0, 32'h0000_0020},
    '{OP_WW, 4'd5,  12'h018, 64'h4, 32'h0},
    '{OP_OT, 4'd5,  12'h000, 64'h0, 32'h0000_0020},            // R5 level kept
    '{OP_SR, 4'd5,  12'h000, 64'h0, 32'h0},
    '{OP_SR, 4'd1,  12'h000, 64'h1, 32'h0},
    '{OP_OT, 4'd1,  12'h000, 64'h0, 32'h0000_0020},            // R1 rise
    '{OP_WW, 4'd1,  12'h018, 64'h1, 32'h0},
    '{OP_OT, 4'd1,  12'h000, 64'h0, 32'h0},
    '{OP_SR, 4'd1,  12'h000, 64'h1, 32'h0},
    '{OP_OT, 4'd1,  12'h000, 64'h0, 32'h0},                    // R1 held high
    '{OP_SR, 4'd1,  12'h000, 64'h0, 32'h0},
    '{OP_WB, 4'd3,  12'h202, 64'h40, 32'h0},
    '{OP_SR, 4'd3,  12'h000, 64'h4, 32'h0},
    '{OP_OT, 4'd3,  12'h000, 64'h0, 32'h0},                    // R3 out of range
    '{OP_SR, 4'd3,  12'h000, 64'h0, 32'h0},
    '{OP_WB, 4'd3,  12'h202, 64'h1F, 32'h0},
    '{OP_SR, 4'd3,  12'h000, 64'h4, 32'h0},
    '{OP_OT, 4'd3,  12'h000, 64'h0, 32'h8000_0000},            // R3 top output
    '{OP_SR, 4'd3,  12'h000, 64'h0, 32'h0},
    '{OP_WW, 4'd9,  12'h00C, 64'hFFFF_FEFF, 32'h0},
    '{OP_RW, 4'd9,  12'h008, 64'h0, 32'hFFFF_FFFA},            // R9
    '{OP_WB, 4'd9,  12'h228, 64'h3, 32'h0},
    '{OP_SR, 4'd9,  12'h000, 64'h0000_0100_0000_0000, 32'h0},
    '{OP_OT, 4'd9,  12'h000, 64'h0, 32'h0000_0008},            // R9 high source
    '{OP_SR, 4'd9,  12'h000, 64'h0, 32'h0},
    '{OP_WW, 4'd6,  12'h040, 64'h1, 32'h0},
    '{OP_OT, 4'd6,  12'h000, 64'h0, 32'h0000_0020},            // R6 sw write
    '{OP_RW, 4'd6,  12'h040, 64'h0, 32'h0000_0001},
    '{OP_WW, 4'd6,  12'h040, 64'h0, 32'h0},
    '{OP_OT, 4'd6,  12'h000, 64'h0, 32'h0},
    '{OP_WW, 4'd10, 12'h028, 64'h1234_5678, 32'h0},
    '{OP_RW, 4'd10, 12'h028, 64'h0, 32'h0},                    // R10 auto zero
    '{OP_WW, 4'd10, 12'h024, 64'hA5A5, 32'h0},
    '{OP_RW, 4'd10, 12'h024, 64'h0, 32'h0000_A5A5},            // R10
    '{OP_WW, 4'd10, 12'h04C, 64'hDEAD, 32'h0},
    '{OP_RW, 4'd10, 12'h04C, 64'h0, 32'h0000_DEAD},            // R10 R12
    '{OP_WB, 4'd10, 12'h13F, 64'h77, 32'h0},
    '{OP_RB, 4'd10, 12'h13F, 64'h0, 32'h0000_0077}             // R10
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] src_in;
  logic            reg_wr, reg_rd, reg_byte;
  logic [11:0]     reg_addr;
  logic [31:0]     reg_wdata;
  logic [31:0]     reg_rdata;
  logic [NOUT-1:0] irq_out;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vec_irq_ctrl #(.NSRC(NSRC), .NOUT(NOUT)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_in    (src_in),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_byte  (reg_byte),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out)
  );

  task automatic check(input int req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
  endtask

  task automatic rd(input logic byte_sel, input logic [11:0] a, output logic [31:0] v);
    reg_rd = 1'b1; reg_byte = byte_sel; reg_addr = a;
    cycle();
    v = reg_rdata;
    reg_rd = 1'b0; reg_byte = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; src_in = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_byte = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    repeat (3) cycle();
    rst_n = 1'b1;
    repeat (4) cycle();
    check(8, "outputs after reset", irq_out, 32'h0);                // R8

    for (int i = 0; i < NSTEP; i++) begin
      case (TBL[i].op)
        OP_WW, OP_WB: begin
          reg_wr = 1'b1; reg_byte = (TBL[i].op == OP_WB);
          reg_addr = TBL[i].addr; reg_wdata = TBL[i].data[31:0];
          cycle();
          reg_wr = 1'b0; reg_byte = 1'b0;
        end
        OP_RW, OP_RB: begin
          rd(TBL[i].op == OP_RB, TBL[i].addr, v);
          check(int'(TBL[i].req), $sformatf("read %h step %0d", TBL[i].addr, i),
                v, TBL[i].exp);
        end
        OP_SR: begin
          src_in = TBL[i].data;
          cycle();
        end
        default: begin
          check(int'(TBL[i].req), $sformatf("irq_out step %0d", i), irq_out, TBL[i].exp);
        end
      endcase
    end

    // Directed: reset in mid-run restores every value (R8)
    src_in = '0;
    rst_n = 1'b0;
    repeat (2) cycle();
    check(8, "outputs in reset", irq_out, 32'h0);
    check(8, "rdata in reset", reg_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (4) cycle();
    rd(1'b0, 12'h008, v); check(8, "mask low reset", v, 32'hFFFF_FFFF);
    rd(1'b0, 12'h00C, v); check(8, "mask high reset", v, 32'hFFFF_FFFF);
    rd(1'b0, 12'h010, v); check(8, "edge low reset", v, 32'h0);
    rd(1'b0, 12'h04C, v); check(8, "polarity high reset", v, 32'h0);
    rd(1'b0, 12'h040, v); check(8, "status low reset", v, 32'h0);
    rd(1'b1, 12'h13F, v); check(8, "route byte reset", v, 32'h01);
    rd(1'b1, 12'h228, v); check(8, "vector byte reset", v, 32'h00);

    // Directed: read latency and idle read data (R11)
    rd(1'b0, 12'h004, v); check(11, "ID one cycle after strobe", v, 32'h003F_0001);
    cycle();
    check(11, "rdata idle after no strobe", reg_rdata, 32'h0);

    // Directed: level source with mask set never reaches an output (R4)
    reg_wr = 1'b1; reg_addr = 12'h008; reg_wdata = 32'hFFFF_FFFF; cycle(); reg_wr = 1'b0;
    src_in = 64'h8; cycle();
    check(4, "masked level source", irq_out, 32'h0);
    src_in = '0; cycle();

    finish_run();
  end
endmodule